// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Timer

This block drives one pulse-width modulated output from a clock that is first slowed by a power-of-two prescaler. Software programs it through a small 32-bit register bus with two registers. One holds the run bit, the staging bit, a stored source-select bit and a split prescaler exponent. The other holds a 10-bit period and a 10-bit high-phase length, both counted in prescaled ticks.

Values written to the period, phase and prescaler fields first land in shadow storage. They are copied into the working set as one group. The copy happens at once while the channel is idle. While the channel runs, it happens only at the end of a period. Software can hold the copy back by setting the staging bit, write all new values, and then clear the bit so that they take effect together. A period or phase of zero is a prohibited setting: the channel will not run on it, so a 0% duty cycle cannot be produced. The output is always active-high.

Top module: `pwm_timer`

## Requirements
- R1: After the synchronous reset, `pwm_out` is 0 and both registers read back as 0x00000000.
- R2: The control register is at byte address 0x0. Its readable fields are bits 19:16 (prescaler high part), bit 15 (prescaler low bit), bit 11 (staging), bit 4 (source select) and bit 0 (run). The count register is at byte address 0x4, with the period in bits 25:16 and the phase in bits 9:0. A read returns the last value written to these fields and 0 in every other bit. The read data appears on `bus_rdata` one clock after `bus_rd`. Reads of any other address return 0, and writes to any other address change nothing.
- R3: While running with period P and phase H < P, the output is a repeating waveform of P·2^E clocks that is high for the first H·2^E clocks of each period.
- R4: The prescaler exponent is E = 2 × (bits 19:16) + bit 15. One tick lasts 2^E clocks.
- R5: If the phase is greater than or equal to the period, the output stays high for as long as the channel runs.
- R6: If the working period or the working phase is 0, the channel does not run and `pwm_out` stays 0, even with the run bit set.
- R7: Clearing the run bit drives `pwm_out` low within 2 clocks. Setting it again restarts at tick 0, so the output goes high one clock after the control write and the first high run lasts H·2^E clocks.
- R8: While the staging bit is 1, writes to the period, phase and prescaler fields do not change the waveform. These writes are still returned by reads.
- R9: Once the staging bit is 0, pending values take effect together. This happens at once when the channel is not running, and at the next period end when it is running.
- R10: A count-register write made mid-period while running, with staging at 0, lets the current period finish with the old values. The next period uses the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and for the prescaler |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read strobe for one clock |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the clock after `bus_rd` |
| pwm_out | output | 1 | Registered pulse output, active high |

## Verification
The hardest behaviour to reach is the deferred commit while running: new values must wait out the rest of the current period and then switch exactly at its end. The stimulus first locks onto a rising edge of the output, then writes new counts a couple of clocks into a known eight-clock period. It then measures the distance to the next rising edge and the shape of the following period. The staged path is reached the same way: the bench sets the staging bit mid-run, confirms that whole periods keep the old shape, and then clears the bit to release the new values.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // field sizes
  localparam int TICK_W   = 10;
  localparam int EXP_W    = 5;
  localparam int PS_HI_W  = 4;

  // register byte offsets
  localparam int CTRL_OFS  = 0;
  localparam int COUNT_OFS = 4;

  // control register bit positions
  localparam int PS_HI_LSB = 16;
  localparam int PS_LO_BIT = 15;
  localparam int STAGE_BIT = 11;
  localparam int SRC_BIT   = 4;
  localparam int RUN_BIT   = 0;

  // count register bit positions
  localparam int PER_LSB = 16;
  localparam int PH_LSB  = 0;

  typedef struct packed {
    logic [TICK_W-1:0] per;
    logic [TICK_W-1:0] ph;
    logic [EXP_W-1:0]  exp;
  } timing_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int MAX_EXP = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  output logic [DATA_W-1:0] rdata,
  output timing_t           act,
  output logic              go,
  output logic              en_q,
  output logic              stage_q
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(COUNT_OFS);
  localparam logic [EXP_W-1:0]  EXP_CAP = EXP_W'(MAX_EXP);

  logic [PS_HI_W-1:0] ps_hi_q;
  logic               ps_lo_q;
  logic               src_q;
  logic [TICK_W-1:0]  sh_per_q;
  logic [TICK_W-1:0]  sh_ph_q;
  logic               pending_q;

  logic               hit_ctrl;
  logic               hit_count;
  logic               commit;
  logic [EXP_W-1:0]   raw_exp;
  timing_t            staged;
  logic [DATA_W-1:0]  ctrl_view;
  logic [DATA_W-1:0]  count_view;
  logic               unused_wbits;

  assign hit_ctrl  = wr_en && (addr == A_CTRL);
  assign hit_count = wr_en && (addr == A_COUNT);
  assign unused_wbits = ^wdata;

  // exponent = high field doubled plus the low bit, capped at MAX_EXP
  assign raw_exp    = {ps_hi_q, ps_lo_q};
  assign staged.per = sh_per_q;
  assign staged.ph  = sh_ph_q;
  assign staged.exp = (raw_exp > EXP_CAP) ? EXP_CAP : raw_exp;

  // the channel runs only on a legal working set
  assign go = en_q && (act.per != '0) && (act.ph != '0);

  // shadow to working copy: never while staging, else when idle or at period end
  assign commit = pending_q && !stage_q && (!go || wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_hi_q <= '0;
      ps_lo_q <= 1'b0;
      stage_q <= 1'b0;
      src_q   <= 1'b0;
      en_q    <= 1'b0;
    end else if (hit_ctrl) begin
      ps_hi_q <= wdata[PS_HI_LSB +: PS_HI_W];
      ps_lo_q <= wdata[PS_LO_BIT];
      stage_q <= wdata[STAGE_BIT];
      src_q   <= wdata[SRC_BIT];
      en_q    <= wdata[RUN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_per_q <= '0;
      sh_ph_q  <= '0;
    end else if (hit_count) begin
      sh_per_q <= wdata[PER_LSB +: TICK_W];
      sh_ph_q  <= wdata[PH_LSB +: TICK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
    end else if (hit_ctrl || hit_count) begin
      pending_q <= 1'b1;
    end else if (commit) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '0;
    end else if (commit) begin
      act <= staged;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[PS_HI_LSB +: PS_HI_W] = ps_hi_q;
    ctrl_view[PS_LO_BIT] = ps_lo_q;
    ctrl_view[STAGE_BIT] = stage_q;
    ctrl_view[SRC_BIT]   = src_q;
    ctrl_view[RUN_BIT]   = en_q;
  end

  always_comb begin
    count_view = '0;
    count_view[PER_LSB +: TICK_W] = sh_per_q;
    count_view[PH_LSB +: TICK_W]  = sh_ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == A_CTRL) begin
        rdata <= ctrl_view;
      end else if (addr == A_COUNT) begin
        rdata <= count_view;
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int MAX_EXP = 24,
  parameter int EXP_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [EXP_W-1:0] exp,
  output logic             tick
);
  generate
    if (MAX_EXP == 0) begin : g_bypass
      logic unused_in;
      assign unused_in = ^{clk, rst, exp};
      assign tick = go;
    end else begin : g_div
      localparam int PRE_W = MAX_EXP;
      logic [PRE_W:0]   span;
      logic [PRE_W-1:0] lim;
      logic [PRE_W-1:0] pre_q;

      // 2^exp clocks per tick; the counter compares against 2^exp - 1
      assign span = ((PRE_W+1)'(1) << exp) - (PRE_W+1)'(1);
      assign lim  = span[PRE_W-1:0];
      assign tick = go && (pre_q == lim);

      always_ff @(posedge clk) begin
        if (rst || !go) begin
          pre_q <= '0;
        end else if (tick) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int TICK_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              tick,
  input  logic [TICK_W-1:0] per,
  input  logic [TICK_W-1:0] ph,
  output logic [TICK_W-1:0] cnt,
  output logic              wrap,
  output logic              pwm_out
);
  logic last;

  assign last = (cnt == per - TICK_W'(1));
  assign wrap = tick && last;

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= last ? '0 : cnt + TICK_W'(1);
    end
  end

  // high while the tick count is below the phase value
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= go && (cnt < ph);
    end
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int MAX_EXP = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  timing_t           act;
  logic [TICK_W-1:0] act_per;
  logic [TICK_W-1:0] act_ph;
  logic [EXP_W-1:0]  act_exp;
  logic              go;
  logic              en_q;
  logic              stage_q;
  logic              tick;
  logic              wrap;
  logic [TICK_W-1:0] cnt;

  assign act_per = act.per;
  assign act_ph  = act.ph;
  assign act_exp = act.exp;

  pwm_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (32),
    .MAX_EXP(MAX_EXP)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .wrap   (wrap),
    .rdata  (bus_rdata),
    .act    (act),
    .go     (go),
    .en_q   (en_q),
    .stage_q(stage_q)
  );

  pwm_prescale #(
    .MAX_EXP(MAX_EXP),
    .EXP_W  (EXP_W)
  ) u_pre (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .exp (act_exp),
    .tick(tick)
  );

  pwm_wave #(
    .TICK_W(TICK_W)
  ) u_wave (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .tick   (tick),
    .per    (act_per),
    .ph     (act_ph),
    .cnt    (cnt),
    .wrap   (wrap),
    .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int TICK_W = 10,
  parameter int EXP_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              en_q,
  input logic              stage_q,
  input logic              go,
  input logic              wrap,
  input logic              pwm_out,
  input logic [31:0]       bus_rdata,
  input logic [TICK_W-1:0] cnt,
  input logic [TICK_W-1:0] act_per,
  input logic [TICK_W-1:0] act_ph,
  input logic [EXP_W-1:0]  act_exp
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!pwm_out && bus_rdata == 32'h0));

  assert_count_in_period_R3: assert property (@(posedge clk) disable iff (rst)
    go |-> (cnt < act_per));

  assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
    (go && act_ph >= act_per) |=> pwm_out);

  assert_zero_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (act_per == '0 || act_ph == '0) |=> !pwm_out);

  assert_off_is_low_R7: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !pwm_out);

  assert_staged_hold_R8: assert property (@(posedge clk) disable iff (rst)
    stage_q |=> ($stable(act_per) && $stable(act_ph) && $stable(act_exp)));

  assert_commit_at_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (go && !wrap) |=> ($stable(act_per) && $stable(act_ph) && $stable(act_exp)));
endmodule

bind pwm_timer pwm_timer_chk #(
  .TICK_W(pwm_pkg::TICK_W),
  .EXP_W (pwm_pkg::EXP_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_q     (en_q),
  .stage_q  (stage_q),
  .go       (go),
  .wrap     (wrap),
  .pwm_out  (pwm_out),
  .bus_rdata(bus_rdata),
  .cnt      (cnt),
  .act_per  (act_per),
  .act_ph   (act_ph),
  .act_exp  (act_exp)
);

// File: tb/sim_pwm_timer.sv
module sim_pwm_timer;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          pwm_out;

  always #4 clk = ~clk;

  pwm_timer #(.ADDR_W(AW)) u0 (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard for register reads
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic [31:0] mon_exp;
  string       mon_tag;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected read response", bus_rdata, 0);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        chk(bus_rdata == mon_exp, mon_tag, bus_rdata, mon_exp);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] cw(input int en, input int stage, input int e);
    return 32'(en & 1) | (32'(stage & 1) << 11) | (32'(e & 1) << 15) | (32'(e >> 1) << 16);
  endfunction

  function automatic logic [31:0] cntw(input int per, input int ph);
    return (32'(per) << 16) | 32'(ph);
  endfunction

  // waits for the next rising edge of the output, then measures one period
  task automatic measure(output int hi, output int per);
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    hi = 0;
    while (pwm_out) begin hi++; @(negedge clk); end
    per = hi;
    while (!pwm_out) begin per++; @(negedge clk); end
  endtask

  task automatic hold(input logic lvl, input int n, input string req);
    int miss = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out !== lvl) miss++;
    end
    chk(miss == 0, req, miss, 0);
  endtask

  task automatic run_cfg(input int per, input int ph, input int e);
    wr(0, cw(0, 0, e));
    wr(4, cntw(per, ph));
    wr(0, cw(1, 0, e));
  endtask

  task automatic check_shape(input int per, input int ph, input int e, input string req);
    int hi, pd;
    measure(hi, pd);
    chk(hi == (ph << e), {req, " high clocks"}, hi, ph << e);
    chk(pd == (per << e), {req, " period clocks"}, pd, per << e);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, pd, c0, c1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1 output after reset", pwm_out, 0);
    rd(0, 32'h0, "R1 control after reset");
    rd(4, 32'h0, "R1 count after reset");

    // R2 readback masks and unmapped address; R8 staged zeros keep channel idle
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h000F_8811, "R2 control readback mask");
    wr(4, 32'hFFFF_FFFF);
    rd(4, 32'h03FF_03FF, "R2 count readback mask");
    wr(8, 32'h1234_5678);
    rd(8, 32'h0, "R2 unmapped read");
    rd(4, 32'h03FF_03FF, "R2 count after unmapped write");
    rd(0, 32'h000F_8811, "R2 control after unmapped write");
    hold(1'b0, 20, "R8 staged values not applied");
    wr(0, 32'h0);

    // R6 prohibited zero settings
    wr(4, cntw(6, 0));
    wr(0, cw(1, 0, 0));
    hold(1'b0, 30, "R6 zero phase keeps output low");
    wr(4, cntw(0, 4));
    hold(1'b0, 30, "R6 zero period keeps output low");
    wr(0, 32'h0);

    // R3 basic waveforms
    run_cfg(10, 3, 0);
    check_shape(10, 3, 0, "R3 per10 ph3");
    run_cfg(7, 5, 0);
    check_shape(7, 5, 0, "R3 per7 ph5");

    // R4 exponent split across fields
    run_cfg(4, 1, 1);
    check_shape(4, 1, 1, "R4 exp1");
    run_cfg(3, 2, 2);
    check_shape(3, 2, 2, "R4 exp2");
    run_cfg(6, 2, 3);
    check_shape(6, 2, 3, "R4 exp3");

    // R7 disable forces low, re-enable restarts at tick 0; R9 idle commit is immediate
    wr(0, cw(0, 0, 3));
    @(negedge clk);
    chk(pwm_out == 1'b0, "R7 low within 2 clocks of disable", pwm_out, 0);
    hold(1'b0, 20, "R7 stays low while disabled");
    wr(0, cw(0, 0, 0));
    wr(4, cntw(5, 2));
    wr(0, cw(1, 0, 0));
    @(negedge clk);
    chk(pwm_out == 1'b1, "R7 high one clock after enable", pwm_out, 1);
    hi = 0;
    while (pwm_out) begin hi++; @(negedge clk); end
    chk(hi == 2, "R9 first high run uses values written while idle", hi, 2);

    // R5 phase at or above period
    run_cfg(10, 12, 0);
    @(negedge clk);
    hold(1'b1, 60, "R5 phase above period stays high");
    run_cfg(9, 9, 1);
    @(negedge clk);
    hold(1'b1, 60, "R5 phase equal period stays high");

    // R8 staging holds the waveform, R9 release applies new values
    run_cfg(10, 3, 0);
    wr(0, cw(1, 1, 0));
    wr(4, cntw(6, 5));
    rd(4, cntw(6, 5), "R8 staged count reads back");
    check_shape(10, 3, 0, "R8 staged run A");
    check_shape(10, 3, 0, "R8 staged run B");
    wr(0, cw(1, 0, 0));
    measure(hi, pd);
    check_shape(6, 5, 0, "R9 released values");

    // R10 mid-period write waits for the period end
    run_cfg(8, 2, 0);
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    c0 = cyc;
    wr(4, cntw(5, 4));
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    c1 = cyc;
    chk((c1 - c0) == 8, "R10 old period completes", c1 - c0, 8);
    check_shape(5, 4, 0, "R10 next period new values");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule